// File: doc/BRIEF.md
# Host-to-ISA Memory Cycle Bridge

This bridge turns a host processor's memory request into a 16-bit ISA memory cycle. The host starts a request with a one-clock low pulse on its address strobe. It carries a 24-bit byte address, a direction bit and a 16-bit write word. The host always requests a whole word, so address bit 0 is ignored. The host waits until the bridge pulses its ready line low. Read data is valid during that pulse.

The host bus gives no early copy of the next address. For that reason the bridge drives the upper address lines for one full clock before any command strobe. At the end of that clock it samples the card's 16-bit-capable input. A card that claims the access gets one 16-bit transfer. Otherwise the bridge makes two 8-bit transfers: even byte first, then odd byte. Both 8-bit transfers use data lane D[7:0]. During each command phase the bridge watches the zero-wait-state input and ends the transfer early when it is asserted.

Top module: `isa_mem_bridge`

## Requirements
- R1: When the host strobe is sampled low while the bridge is idle, the next cycle and every cycle of that access show host address bits 23..17 on `isa_la` and bits 16..1 on `isa_sa`. These values stay the same even if the host address input changes afterwards.
- R2: Every command phase is preceded by exactly one clock in which `isa_memr_n` and `isa_memw_n` are both high and the address is already driven.
- R3: If `isa_cs16_n` is low at the end of the first address clock, the access is a single transfer. During its command phase `isa_a0`=0 and `isa_sbhe_n`=0, and a read returns all of `isa_din` to the host.
- R4: If `isa_cs16_n` is high at that point, the access is split into two transfers. The first has `isa_a0`=0 and `isa_sbhe_n`=1; the second has `isa_a0`=1 and `isa_sbhe_n`=0. A read takes the low byte from `isa_din[7:0]` in the first transfer and the high byte from `isa_din[7:0]` in the second. `isa_din[15:8]` is ignored.
- R5: A read drives `isa_memr_n` low and a write drives `isa_memw_n` low; the two are never low together. During a write command `isa_doe`=1. `isa_dout` carries the whole word for a single transfer, and for a split write it carries {8'h00, low byte} and then {8'h00, high byte}.
- R6: If `isa_zws_n` is low at the end of the second command clock, the command lasts exactly 2 clocks.
- R7: Otherwise the command lasts exactly CMD_CLKS clocks (3 by default).
- R8: `hst_ready_n` is low for exactly one clock, the clock right after the last command clock, with `hst_rdata` holding the assembled read word. After that the bridge is idle, with the strobes high and ready high.
- R9: A host strobe pulse that arrives while an access is in progress is ignored. The timing and address of the current access are unchanged, and no further ISA cycle follows.
- R10: While reset is held and right after it, both command strobes and `hst_ready_n` are high and `isa_doe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_ads_n | input | 1 | Host request strobe, active low |
| hst_addr | input | 24 | Host byte address |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_wdata | input | 16 | Host write word |
| hst_ready_n | output | 1 | Access complete, active low |
| hst_rdata | output | 16 | Read word returned to the host |
| isa_la | output | 7 | Early upper address bits 23..17 |
| isa_sa | output | 16 | System address bits 16..1 |
| isa_a0 | output | 1 | Byte address bit 0 |
| isa_sbhe_n | output | 1 | High byte enable, active low |
| isa_memr_n | output | 1 | Memory read command, active low |
| isa_memw_n | output | 1 | Memory write command, active low |
| isa_cs16_n | input | 1 | Card can do a 16-bit transfer, active low |
| isa_zws_n | input | 1 | Card requests zero wait states, active low |
| isa_din | input | 16 | Data from the ISA bus |
| isa_dout | output | 16 | Data to the ISA bus |
| isa_doe | output | 1 | Drive enable for `isa_dout` |

## Verification
The hardest case to reach from the ports is a second host strobe that lands inside the command phase of a split, zero-wait-state access. Here the strobe, the byte-lane swap and the shortened command all overlap. The stimulus holds the card inputs steady for the whole access and pulses the host strobe in the first command clock. It also replaces the host address with zero right after the first request. The reference model, built from the requirement timings, then expects the same sequence of strobes, the original address, a single ready pulse and an idle bus.

// File: rtl/isa_mem_bridge.sv
module isa_mem_bridge #(
  parameter int CMD_CLKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hst_ads_n,
  input  logic [23:0] hst_addr,
  input  logic        hst_wr,
  input  logic [15:0] hst_wdata,
  output logic        hst_ready_n,
  output logic [15:0] hst_rdata,
  output logic [6:0]  isa_la,
  output logic [15:0] isa_sa,
  output logic        isa_a0,
  output logic        isa_sbhe_n,
  output logic        isa_memr_n,
  output logic        isa_memw_n,
  input  logic        isa_cs16_n,
  input  logic        isa_zws_n,
  input  logic [15:0] isa_din,
  output logic [15:0] isa_dout,
  output logic        isa_doe
);
  localparam int CW = $clog2(CMD_CLKS + 1);

  typedef enum logic [1:0] {IDLE, ADDR, CMD, DONE} st_t;
  st_t st;

  logic [23:1] lat_a;
  logic        lat_wr, wide, half, fin;
  logic [15:0] lat_wd, rd;
  logic [CW-1:0] cnt;

  assign fin = (cnt == CW'(CMD_CLKS - 1)) || (cnt == CW'(1) && !isa_zws_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; lat_a <= '0; lat_wr <= 1'b0; lat_wd <= '0;
      wide <= 1'b0; half <= 1'b0; cnt <= '0; rd <= '0;
    end else begin
      case (st)
        IDLE: if (!hst_ads_n) begin
          lat_a <= hst_addr[23:1]; lat_wr <= hst_wr; lat_wd <= hst_wdata;
          half <= 1'b0; st <= ADDR;
        end
        ADDR: begin
          if (!half) wide <= !isa_cs16_n;
          cnt <= '0;
          st  <= CMD;
        end
        CMD: if (fin) begin
          if (!lat_wr) begin
            if (wide)       rd       <= isa_din;
            else if (!half) rd[7:0]  <= isa_din[7:0];
            else            rd[15:8] <= isa_din[7:0];
          end
          if (!wide && !half) begin
            half <= 1'b1; st <= ADDR;
          end else st <= DONE;
        end else cnt <= cnt + CW'(1);
        default: st <= IDLE;
      endcase
    end
  end

  assign isa_la      = lat_a[23:17];
  assign isa_sa      = lat_a[16:1];
  assign isa_a0      = half;
  assign isa_sbhe_n  = !(wide || half);
  assign isa_memr_n  = !(st == CMD && !lat_wr);
  assign isa_memw_n  = !(st == CMD && lat_wr);
  assign isa_doe     = (st == CMD) && lat_wr;
  assign isa_dout    = wide ? lat_wd : {8'h00, half ? lat_wd[15:8] : lat_wd[7:0]};
  assign hst_ready_n = !(st == DONE);
  assign hst_rdata   = rd;

  a_r2_addr_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(isa_memr_n) || $fell(isa_memw_n)) |-> $past(st) == ADDR);
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!isa_memr_n && !isa_memw_n));
  a_r4_odd_enables_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((!isa_memr_n || !isa_memw_n) && isa_a0) |-> !isa_sbhe_n);
  a_r6_zws_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CMD && cnt == CW'(1) && !isa_zws_n) |=> st != CMD);
  a_r7_cmd_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CMD) |-> cnt < CW'(CMD_CLKS));
  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !hst_ready_n |=> (hst_ready_n && isa_memr_n && isa_memw_n));
  a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (st != IDLE) |=> $stable(lat_a));
endmodule

// File: tb/sim_isa_mem_bridge.sv
module sim_isa_mem_bridge;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, hst_ads_n, hst_wr, hst_ready_n, isa_a0, isa_sbhe_n;
  logic isa_memr_n, isa_memw_n, isa_cs16_n, isa_zws_n, isa_doe;
  logic [23:0] hst_addr;
  logic [15:0] hst_wdata, hst_rdata, isa_sa, isa_din, isa_dout;
  logic [6:0]  isa_la;

  isa_mem_bridge u0 (
    .clk(clk), .rst_n(rst_n), .hst_ads_n(hst_ads_n), .hst_addr(hst_addr),
    .hst_wr(hst_wr), .hst_wdata(hst_wdata), .hst_ready_n(hst_ready_n),
    .hst_rdata(hst_rdata), .isa_la(isa_la), .isa_sa(isa_sa), .isa_a0(isa_a0),
    .isa_sbhe_n(isa_sbhe_n), .isa_memr_n(isa_memr_n), .isa_memw_n(isa_memw_n),
    .isa_cs16_n(isa_cs16_n), .isa_zws_n(isa_zws_n), .isa_din(isa_din),
    .isa_dout(isa_dout), .isa_doe(isa_doe));

  integer errs = 0, checks = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic xfer(input logic [23:0] a, input bit wr, input logic [15:0] wd,
                      input bit c16, input bit z, input logic [15:0] rdv, input bit poke);
    int halves = c16 ? 1 : 2;
    int len    = z ? 2 : 3;
    string lt  = z ? "R6" : "R7";
    string wt  = c16 ? "R3" : "R4";
    @(negedge clk);
    hst_ads_n = 1'b0; hst_addr = a; hst_wr = wr; hst_wdata = wd;
    isa_cs16_n = !c16; isa_zws_n = !z;
    @(negedge clk);
    hst_ads_n = 1'b1; hst_addr = 24'h0; hst_wdata = 16'h0;
    for (int h = 0; h < halves; h++) begin
      if (h > 0) @(negedge clk);
      isa_din = c16 ? rdv : (h == 0 ? {8'hA5, rdv[7:0]} : {8'h5A, rdv[15:8]});
      chk("R2 strobes off in address clock", {isa_memr_n, isa_memw_n}, 2'b11);
      chk("R1 la", isa_la, a[23:17]);
      chk("R1 sa", isa_sa, a[16:1]);
      for (int k = 0; k < len; k++) begin
        @(negedge clk);
        hst_ads_n = !(poke && h == 0 && k == 0);
        chk("R5 memr", isa_memr_n, wr);
        chk("R5 memw", isa_memw_n, !wr);
        chk({wt, " a0"}, isa_a0, (!c16 && h == 1));
        chk({wt, " sbhe"}, isa_sbhe_n, !(c16 || h == 1));
        chk({lt, " length, ready held"}, hst_ready_n, 1'b1);
        chk("R9 la held", isa_la, a[23:17]);
        if (wr) begin
          chk("R5 doe", isa_doe, 1'b1);
          chk("R5 dout", isa_dout, c16 ? wd : {8'h00, (h == 1) ? wd[15:8] : wd[7:0]});
        end
      end
    end
    @(negedge clk);
    chk({lt, " command ended"}, {isa_memr_n, isa_memw_n}, 2'b11);
    chk("R8 ready low", hst_ready_n, 1'b0);
    if (!wr) chk({wt, " R8 read word"}, hst_rdata, rdv);
    @(negedge clk);
    chk("R8 single ready", hst_ready_n, 1'b1);
    chk(poke ? "R9 no extra cycle" : "R8 idle", {isa_memr_n, isa_memw_n}, 2'b11);
    @(negedge clk);
    chk(poke ? "R9 still idle" : "R8 still idle", {isa_memr_n, isa_memw_n, hst_ready_n}, 3'b111);
  endtask

  initial begin
    #1600000;
    errs++;
    $display("FAIL watchdog got=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hst_ads_n = 1'b1; hst_addr = '0; hst_wr = 1'b0; hst_wdata = '0;
    isa_cs16_n = 1'b1; isa_zws_n = 1'b1; isa_din = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", {isa_memr_n, isa_memw_n, hst_ready_n, isa_doe}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after reset", {isa_memr_n, isa_memw_n, hst_ready_n, isa_doe}, 4'b1110);
    xfer(24'hC3_4568, 1'b0, 16'h0, 1'b1, 1'b1, 16'hBEEF, 1'b0);
    xfer(24'h81_2346, 1'b0, 16'h0, 1'b1, 1'b0, 16'h1357, 1'b0);
    xfer(24'h0A_BCDE, 1'b0, 16'h0, 1'b0, 1'b1, 16'hCAFE, 1'b0);
    xfer(24'hFE_0002, 1'b0, 16'h0, 1'b0, 1'b0, 16'h8421, 1'b0);
    xfer(24'h55_AAAA, 1'b1, 16'h1234, 1'b1, 1'b1, 16'h0, 1'b0);
    xfer(24'h2B_0010, 1'b1, 16'h9A7C, 1'b0, 1'b0, 16'h0, 1'b0);
    xfer(24'hE1_F00E, 1'b0, 16'h0, 1'b0, 1'b1, 16'h6D3B, 1'b1);
    xfer(24'h3C_1110, 1'b1, 16'hF00D, 1'b1, 1'b0, 16'h0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule